// File: doc/BRIEF.md
# Timekeeping NVRAM register file

This block models a byte-wide battery-backed RAM whose highest eight locations are taken over by a real-time clock. A host reaches it over a simple synchronous bus: it presents an address with a read or write strobe, and read data comes back one clock later. The bus address is folded onto the RAM window, so every window-sized copy of the address range reaches the same byte. The default window is 2 KB. Setting `ADDR_W` to 13 gives the full 8 KB part with its clock at 0x1FF8.

At the top of the window, offset 0 is a control byte and offsets 1 to 7 are seconds, minutes, hours, weekday with century flag, date, month and year. A once-per-second pulse on `pps_tick` advances the calendar, which is kept in packed BCD. Each write to a clock field is masked and range-checked, and a write whose value is out of range leaves that field as it was. Bit 7 of the seconds location is a stop flag that freezes the calendar until it is cleared.

Top module: `tk_nvram`

## Requirements
- R1: Only the low `ADDR_W` bits of `bus_addr` are decoded, so an address plus any multiple of 2^`ADDR_W` reaches the same byte or clock field.
- R2: Every location below the top eight, and offset 0 itself, behaves as a plain read/write byte. Reset does not alter RAM contents.
- R3: A write to clock offset 0 stores the written byte with bits 7 and 5 cleared and then bits 7 and 4 set, i.e. `(d & 0x5F) | 0x90`. A read returns that stored byte.
- R4: A write to offset 1 always loads the stop flag from bit 7. It loads seconds only when bits 6:4 × 10 + bits 3:0 is at most 59. A read of offset 1 returns the stop flag in bit 7 and BCD seconds in bits 6:0.
- R5: Minutes (offset 2) load from bits 6:0 when the decoded value is at most 59. Hours (offset 3) load from bits 5:0 when the decoded value is at most 23. A rejected value changes nothing. Reads return packed BCD, tens in the upper nibble.
- R6: A write to offset 4 loads the weekday from bits 2:0 and a century flag from bit 6. A read returns the flag in bit 6 ORed with the weekday in bits 2:0.
- R7: Date (offset 5) loads from bits 4:0 when the decoded value is nonzero. Month (offset 6) loads from bits 4:0 when it decodes to 1–12. Year (offset 7) loads the whole byte when it decodes to 0–99. All three read as packed BCD.
- R8: Each `pps_tick` with the stop flag clear advances seconds. Seconds carry into minutes after 59, minutes into hours after 59, and hours into the day after 23. A day step moves the weekday (7 wraps to 1) and the date. The date wraps to 1 after 28 in month 2, after 30 in months 4, 6, 9 and 11, and after 31 otherwise, carrying into the month. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 00.
- R9: While the stop flag is set, ticks leave every calendar field unchanged. Clearing the flag resumes counting from the held value.
- R10: Reset clears the stop and century flags and sets 00:00:00, weekday 1, date 01, month 01, year 00. `bus_rdata` reads 0x00 until the first read.
- R11: Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read.
- R12: When a bus write and a tick fall in the same cycle, an accepted written value wins for that field, and the other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Byte address, folded to `ADDR_W` bits |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| pps_tick | input | 1 | One-cycle pulse per second |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_re` |

## Verification
The bench drives several patterns and compares each against a behavioural model:
- Legal, illegal and mask-edge writes to every clock field show whether the range checks and bit masks accept exactly the right values.
- Long stretches of free-running ticks with rotating reads exercise the seconds-to-minutes carry.
- Loading 23:59:59 before single ticks walks the date across month ends of 28, 30 and 31 days and across the year wrap.
- Writes that coincide with ticks, stop-flag toggles under ticking, and a mid-run reset tell write priority, freezing and reset scope apart from ordinary counting.

// File: rtl/tk_nvram_pkg.sv
package tk_nvram_pkg;

  typedef logic [7:0] bcd8_t;

  // offsets inside the top eight locations
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_SEC   = 3'd1,
    REG_MIN   = 3'd2,
    REG_HOUR  = 3'd3,
    REG_WDAY  = 3'd4,
    REG_DATE  = 3'd5,
    REG_MONTH = 3'd6,
    REG_YEAR  = 3'd7
  } clk_reg_e;

  // counting fields, index order is the carry order
  localparam int NFIELD  = 6;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DATE  = 3;
  localparam int F_MONTH = 4;
  localparam int F_YEAR  = 5;

  // low (wrap and reset) value and static high value per field
  localparam logic [NFIELD*8-1:0] FIELD_LO = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [NFIELD*8-1:0] FIELD_HI = {8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59};

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic bcd8_t bin_to_bcd(input logic [7:0] b);
    logic [7:0] t;
    logic [7:0] u;
    t = b / 8'd10;
    u = b - (t * 8'd10);
    return {t[3:0], u[3:0]};
  endfunction

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcd8_t month_days(input bcd8_t m);
    case (m)
      8'h02:                      return 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/tk_ram.sv
module tk_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // single port, read-first, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/tk_bcd_field.sv
module tk_bcd_field
  import tk_nvram_pkg::*;
#(
  parameter bcd8_t LO = 8'h00
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  inc,
  input  logic  load,
  input  bcd8_t load_val,
  input  bcd8_t hi,
  output bcd8_t q,
  output logic  at_hi
);
  assign at_hi = (q >= hi);

  // bus load takes priority over the count step
  always_ff @(posedge clk) begin
    if (rst)       q <= LO;
    else if (load) q <= load_val;
    else if (inc)  q <= at_hi ? LO : bcd_inc(q);
  end
endmodule

// File: rtl/tk_calendar.sv
module tk_calendar
  import tk_nvram_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     wr_en,
  input  clk_reg_e wr_reg,
  input  logic [7:0] wr_data,
  output bcd8_t    sec_q,
  output bcd8_t    min_q,
  output bcd8_t    hour_q,
  output logic [2:0] wday_q,
  output bcd8_t    date_q,
  output bcd8_t    month_q,
  output bcd8_t    year_q,
  output logic     stop_q,
  output logic     century_q
);
  logic [NFIELD-1:0] inc;
  logic [NFIELD-1:0] load;
  logic [NFIELD-1:0] wrap;
  bcd8_t             q  [NFIELD];
  bcd8_t             hi [NFIELD];
  bcd8_t             ld_val;
  logic [7:0]        raw;
  logic              ok;
  logic              has_field;
  logic [2:0]        fsel;
  logic              unused_year_wrap;

  // carry chain
  assign inc[0] = tick & ~stop_q;
  generate
    for (genvar i = 1; i < NFIELD; i++) begin : g_carry
      assign inc[i] = inc[i-1] & wrap[i-1];
    end
  endgenerate
  assign unused_year_wrap = wrap[NFIELD-1];

  // write decode: mask, decode, range check
  always_comb begin
    raw       = '0;
    ok        = 1'b0;
    has_field = 1'b0;
    fsel      = 3'd0;
    case (wr_reg)
      REG_SEC: begin
        raw = bcd_to_bin({1'b0, wr_data[6:0]});
        ok = (raw <= 8'd59); has_field = 1'b1; fsel = 3'(F_SEC);
      end
      REG_MIN: begin
        raw = bcd_to_bin({1'b0, wr_data[6:0]});
        ok = (raw <= 8'd59); has_field = 1'b1; fsel = 3'(F_MIN);
      end
      REG_HOUR: begin
        raw = bcd_to_bin({2'b0, wr_data[5:0]});
        ok = (raw <= 8'd23); has_field = 1'b1; fsel = 3'(F_HOUR);
      end
      REG_DATE: begin
        raw = bcd_to_bin({3'b0, wr_data[4:0]});
        ok = (raw != 8'd0); has_field = 1'b1; fsel = 3'(F_DATE);
      end
      REG_MONTH: begin
        raw = bcd_to_bin({3'b0, wr_data[4:0]});
        ok = (raw >= 8'd1) && (raw <= 8'd12); has_field = 1'b1; fsel = 3'(F_MONTH);
      end
      REG_YEAR: begin
        raw = bcd_to_bin(wr_data);
        ok = (raw <= 8'd99); has_field = 1'b1; fsel = 3'(F_YEAR);
      end
      default: begin
        has_field = 1'b0;
      end
    endcase
    load = '0;
    if (wr_en && has_field && ok) load[fsel] = 1'b1;
  end

  assign ld_val = bin_to_bcd(raw);

  generate
    for (genvar i = 0; i < NFIELD; i++) begin : g_field
      if (i == F_DATE) begin : g_dyn
        assign hi[i] = month_days(q[F_MONTH]);
      end else begin : g_fix
        assign hi[i] = FIELD_HI[i*8 +: 8];
      end
      tk_bcd_field #(.LO(FIELD_LO[i*8 +: 8])) u_field (
        .clk      (clk),
        .rst      (rst),
        .inc      (inc[i]),
        .load     (load[i]),
        .load_val (ld_val),
        .hi       (hi[i]),
        .q        (q[i]),
        .at_hi    (wrap[i])
      );
    end
  endgenerate

  // weekday steps with the date, flags live beside the counters
  always_ff @(posedge clk) begin
    if (rst) begin
      wday_q    <= 3'd1;
      century_q <= 1'b0;
      stop_q    <= 1'b0;
    end else begin
      if (wr_en && wr_reg == REG_WDAY) begin
        wday_q    <= wr_data[2:0];
        century_q <= wr_data[6];
      end else if (inc[F_DATE]) begin
        wday_q <= (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
      end
      if (wr_en && wr_reg == REG_SEC) stop_q <= wr_data[7];
    end
  end

  assign sec_q   = q[F_SEC];
  assign min_q   = q[F_MIN];
  assign hour_q  = q[F_HOUR];
  assign date_q  = q[F_DATE];
  assign month_q = q[F_MONTH];
  assign year_q  = q[F_YEAR];
endmodule

// File: rtl/tk_nvram.sv
module tk_nvram
  import tk_nvram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BUS_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              pps_tick,
  output logic [7:0]        bus_rdata
);
  logic [ADDR_W-1:0] a;
  logic              clk_area;
  clk_reg_e          roff;
  logic              is_ctrl;
  logic              is_time;
  logic              ram_we;
  logic [7:0]        ram_wd;
  logic [7:0]        ram_q;
  bcd8_t             cal_sec, cal_min, cal_hour, cal_date, cal_month, cal_year;
  logic [2:0]        cal_wday;
  logic              stop_q, century_q;
  logic [7:0]        cal_view;
  logic [7:0]        cal_rd_q;
  logic              rd_from_cal;

  generate
    if (BUS_AW > ADDR_W) begin : g_fold
      logic unused_addr_hi;
      assign unused_addr_hi = ^bus_addr[BUS_AW-1:ADDR_W];
    end
  endgenerate

  assign a        = bus_addr[ADDR_W-1:0];
  assign clk_area = &a[ADDR_W-1:3];
  assign roff     = clk_reg_e'(a[2:0]);
  assign is_ctrl  = clk_area && (roff == REG_CTRL);
  assign is_time  = clk_area && (roff != REG_CTRL);

  assign ram_we = bus_we && !is_time;
  assign ram_wd = is_ctrl ? ((bus_wdata & 8'h5F) | 8'h90) : bus_wdata;

  tk_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk   (clk),
    .addr  (a),
    .we    (ram_we),
    .wdata (ram_wd),
    .re    (bus_re),
    .q     (ram_q)
  );

  tk_calendar u_cal (
    .clk       (clk),
    .rst       (rst),
    .tick      (pps_tick),
    .wr_en     (bus_we && is_time),
    .wr_reg    (roff),
    .wr_data   (bus_wdata),
    .sec_q     (cal_sec),
    .min_q     (cal_min),
    .hour_q    (cal_hour),
    .wday_q    (cal_wday),
    .date_q    (cal_date),
    .month_q   (cal_month),
    .year_q    (cal_year),
    .stop_q    (stop_q),
    .century_q (century_q)
  );

  always_comb begin
    case (roff)
      REG_SEC:   cal_view = cal_sec | {stop_q, 7'd0};
      REG_MIN:   cal_view = cal_min;
      REG_HOUR:  cal_view = cal_hour;
      REG_WDAY:  cal_view = {1'b0, century_q, 3'd0, cal_wday};
      REG_DATE:  cal_view = cal_date;
      REG_MONTH: cal_view = cal_month;
      REG_YEAR:  cal_view = cal_year;
      default:   cal_view = 8'h00;
    endcase
  end

  // clock-side read register, RAM side is registered inside tk_ram
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_from_cal <= 1'b1;
      cal_rd_q    <= 8'h00;
    end else if (bus_re) begin
      rd_from_cal <= is_time;
      cal_rd_q    <= cal_view;
    end
  end

  assign bus_rdata = rd_from_cal ? cal_rd_q : ram_q;
endmodule

// File: rtl/tk_nvram_chk.sv
module tk_nvram_chk
  import tk_nvram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BUS_AW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              pps_tick,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        cal_sec,
  input logic [7:0]        cal_min,
  input logic [7:0]        cal_hour,
  input logic [7:0]        cal_month,
  input logic              stop_q
);
  logic top_hit, sec_hit, min_hit;
  assign top_hit = &bus_addr[ADDR_W-1:3];
  assign sec_hit = top_hit && (bus_addr[2:0] == 3'd1);
  assign min_hit = top_hit && (bus_addr[2:0] == 3'd2);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

  assert_stop_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !(bus_we && sec_hit)) |=> $stable(cal_sec));

  assert_tick_advance_R8: assert property (@(posedge clk) disable iff (rst)
    (pps_tick && !stop_q && !bus_we && cal_sec != 8'h59) |=> (cal_sec != $past(cal_sec)));

  assert_sec_range_R8: assert property (@(posedge clk) disable iff (rst)
    (cal_sec[3:0] <= 4'd9) && (cal_sec[7:4] <= 4'd5));

  assert_hour_month_range_R8: assert property (@(posedge clk) disable iff (rst)
    (cal_hour <= 8'h23) && (cal_month >= 8'h01) && (cal_month <= 8'h12));

  assert_reset_vals_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cal_sec == 8'h00 && cal_min == 8'h00 && cal_month == 8'h01 && !stop_q));

  assert_min_load_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && min_hit && (bcd_to_bin({1'b0, bus_wdata[6:0]}) <= 8'd59))
      |=> (cal_min == bin_to_bcd(bcd_to_bin({1'b0, $past(bus_wdata[6:0])}))));
endmodule

bind tk_nvram tk_nvram_chk #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .pps_tick  (pps_tick),
  .bus_rdata (bus_rdata),
  .cal_sec   (cal_sec),
  .cal_min   (cal_min),
  .cal_hour  (cal_hour),
  .cal_month (cal_month),
  .stop_q    (stop_q)
);

// File: tb/tb_tk_nvram.sv
module tb_tk_nvram;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int TOP   = DEPTH - 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic        pps_tick = 1'b0;
  logic [7:0]  bus_rdata;

  int test_cnt = 0;
  int fail_cnt = 0;
  bit done = 1'b0;
  string cur_tag = "R10";

  tk_nvram #(.ADDR_W(AW), .BUS_AW(16)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .pps_tick(pps_tick), .bus_rdata(bus_rdata));

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int m_sec, m_min, m_hr, m_wd, m_dt, m_mo, m_yr, m_stop, m_cent;
  int mem_m [int];
  bit exp_known = 1'b1;
  int exp_val = 0;
  bit rd_seen = 1'b0;
  int ma, off;
  bit tarea;

  function automatic int fb(int v);
    return ((v >> 4) & 15) * 10 + (v & 15);
  endfunction

  function automatic int tb_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int mlen(int m);
    if (m == 2) return 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int cal_read(int o);
    case (o)
      1: return (m_stop << 7) | tb_bcd(m_sec);
      2: return tb_bcd(m_min);
      3: return tb_bcd(m_hr);
      4: return (m_cent << 6) | m_wd;
      5: return tb_bcd(m_dt);
      6: return tb_bcd(m_mo);
      default: return tb_bcd(m_yr);
    endcase
  endfunction

  function automatic void advance();
    m_sec++;
    if (m_sec > 59) begin
      m_sec = 0; m_min++;
      if (m_min > 59) begin
        m_min = 0; m_hr++;
        if (m_hr > 23) begin
          m_hr = 0;
          m_wd = (m_wd >= 7) ? 1 : m_wd + 1;
          if (m_dt >= mlen(m_mo)) begin
            m_dt = 1; m_mo++;
            if (m_mo > 12) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
          end else m_dt++;
        end
      end
    end
  endfunction

  function automatic void apply_write(int a, bit top, int o, int d);
    int v;
    if (!top) begin mem_m[a] = d; return; end
    case (o)
      0: mem_m[a] = (d & 'h5F) | 'h90;
      1: begin v = fb(d & 'h7F); if (v <= 59) m_sec = v; m_stop = (d >> 7) & 1; end
      2: begin v = fb(d & 'h7F); if (v <= 59) m_min = v; end
      3: begin v = fb(d & 'h3F); if (v <= 23) m_hr = v; end
      4: begin m_wd = d & 7; m_cent = (d >> 6) & 1; end
      5: begin v = fb(d & 'h1F); if (v != 0) m_dt = v; end
      6: begin v = fb(d & 'h1F); if (v >= 1 && v <= 12) m_mo = v; end
      default: begin v = fb(d); if (v <= 99) m_yr = v; end
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_wd = 1; m_dt = 1; m_mo = 1; m_yr = 0;
      m_stop = 0; m_cent = 0;
      exp_known = 1'b1; exp_val = 0; rd_seen = 1'b0;
    end else begin
      ma = int'(bus_addr) & (DEPTH - 1);
      tarea = (ma >= TOP);
      off = ma - TOP;
      rd_seen = bus_re;
      if (bus_re) begin
        if (tarea && off != 0) begin exp_known = 1'b1; exp_val = cal_read(off); end
        else if (mem_m.exists(ma)) begin exp_known = 1'b1; exp_val = mem_m[ma]; end
        else exp_known = 1'b0;
      end
      if (pps_tick && m_stop == 0) advance();
      if (bus_we) apply_write(ma, tarea, off, int'(bus_wdata));
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done && exp_known) begin
      test_cnt++;
      if (bus_rdata !== 8'(exp_val)) begin
        fail_cnt++;
        $display("FAIL %s: bus_rdata=%02h expected %02h at %0t",
                 rd_seen ? cur_tag : ((cur_tag == "R10") ? "R10" : "R11"),
                 bus_rdata, 8'(exp_val), $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input bit we, input bit re, input int a, input int d, input bit tk);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = 16'(a); bus_wdata = 8'(d); pps_tick = tk;
  endtask
  task automatic wr(input int a, input int d); op(1'b1, 1'b0, a, d, 1'b0); endtask
  task automatic rd(input int a);              op(1'b0, 1'b1, a, 0, 1'b0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 0, 0, 1'b0);
  endtask
  task automatic day_step();
    wr(TOP + 3, 'h23); wr(TOP + 2, 'h59); wr(TOP + 1, 'h59);
    op(1'b0, 1'b0, 0, 0, 1'b1);
    rd(TOP + 5); rd(TOP + 4); rd(TOP + 6); rd(TOP + 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset values and idle read data
    idle(2);
    for (int o = 1; o < 8; o++) rd(TOP + o);
    // R2: plain RAM
    cur_tag = "R2";
    wr('h000, 'h11); wr('h123, 'hA5); wr(TOP - 1, 'h3C);
    rd('h000); rd('h123); rd(TOP - 1); idle(2);
    // R1: address folding
    cur_tag = "R1";
    rd('h123 + DEPTH); wr('h055 + 3 * DEPTH, 'h77); rd('h055); rd(TOP + 1 + DEPTH);
    // R3: control byte transform
    cur_tag = "R3";
    wr(TOP, 'hFF); rd(TOP); wr(TOP, 'h00); rd(TOP); wr(TOP, 'h2A); rd(TOP);
    // R4: seconds load and range check
    cur_tag = "R4";
    wr(TOP + 1, 'h45); rd(TOP + 1); wr(TOP + 1, 'h7A); rd(TOP + 1);
    wr(TOP + 1, 'h0F); rd(TOP + 1);
    // R9: stop flag freezes, clearing resumes
    cur_tag = "R9";
    wr(TOP + 1, 'hB0);
    for (int i = 0; i < 5; i++) op(1'b0, 1'b1, TOP + 1, 0, 1'b1);
    wr(TOP + 1, 'h30);
    for (int i = 0; i < 5; i++) op(1'b0, 1'b1, TOP + 1, 0, 1'b1);
    // R5: minutes and hours
    cur_tag = "R5";
    wr(TOP + 2, 'h59); rd(TOP + 2); wr(TOP + 2, 'h60); rd(TOP + 2);
    wr(TOP + 2, 'h0C); rd(TOP + 2);
    wr(TOP + 3, 'h23); rd(TOP + 3); wr(TOP + 3, 'h24); rd(TOP + 3);
    wr(TOP + 3, 'h3F); rd(TOP + 3); wr(TOP + 3, 'h1A); rd(TOP + 3);
    // R6: weekday and century
    cur_tag = "R6";
    wr(TOP + 4, 'h45); rd(TOP + 4); wr(TOP + 4, 'h03); rd(TOP + 4);
    wr(TOP + 4, 'hC7); rd(TOP + 4);
    // R7: date, month, year
    cur_tag = "R7";
    wr(TOP + 5, 'h00); rd(TOP + 5); wr(TOP + 5, 'h1F); rd(TOP + 5);
    wr(TOP + 5, 'h31); rd(TOP + 5);
    wr(TOP + 6, 'h00); rd(TOP + 6); wr(TOP + 6, 'h13); rd(TOP + 6);
    wr(TOP + 6, 'h0B); rd(TOP + 6); wr(TOP + 6, 'h12); rd(TOP + 6);
    wr(TOP + 7, 'h9A); rd(TOP + 7); wr(TOP + 7, 'h0F); rd(TOP + 7);
    wr(TOP + 7, 'h99); rd(TOP + 7);
    // R8: free running carry seconds to minutes
    cur_tag = "R8";
    wr(TOP + 1, 'h00); wr(TOP + 2, 'h00);
    for (int i = 0; i < 150; i++) op(1'b0, 1'b1, TOP + 1 + (i % 3), 0, 1'b1);
    // R8: 28-day month
    wr(TOP + 6, 'h02); wr(TOP + 5, 'h1F); wr(TOP + 4, 'h06);
    for (int i = 0; i < 6; i++) day_step();
    // R8: 30-day month
    wr(TOP + 6, 'h04); wr(TOP + 5, 'h1F);
    for (int i = 0; i < 7; i++) day_step();
    // R8: 31-day month and year wrap
    wr(TOP + 7, 'h99); wr(TOP + 6, 'h12); wr(TOP + 5, 'h1F);
    for (int i = 0; i < 8; i++) day_step();
    // R12: write coincides with tick
    cur_tag = "R12";
    op(1'b1, 1'b0, TOP + 1, 'h10, 1'b1); rd(TOP + 1);
    wr(TOP + 1, 'h59); wr(TOP + 2, 'h07);
    op(1'b1, 1'b0, TOP + 2, 'h33, 1'b1); rd(TOP + 2); rd(TOP + 1);
    op(1'b1, 1'b0, TOP + 2, 'h77, 1'b1); rd(TOP + 2); rd(TOP + 1);
    // R10 and R2: reset mid-run keeps RAM, restores calendar
    cur_tag = "R10";
    @(negedge clk); rst = 1'b1; bus_we = 1'b0; bus_re = 1'b0; pps_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    idle(1);
    for (int o = 1; o < 8; o++) rd(TOP + o);
    cur_tag = "R2";
    rd('h123); rd(TOP); rd('h055);
    idle(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", test_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fail_cnt++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", test_cnt, fail_cnt);
      $finish;
    end
  end
endmodule